// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short history of program-flow discontinuities for a debug host. Each cycle the core may present one flow event, which carries:

- the kind of discontinuity,
- whether a conditional transfer was taken,
- the current program counter,
- the destination address,
- for interrupt entry, the vector address.

A five-bit class mask selects which discontinuities are kept. Any mix of bits may be set at once. Each class fixes which address goes into the store. Direction is not supplied by the core. The block derives it by comparing the destination with the program counter.

Kept addresses go into an eight-entry ring. The host pulls entries out one at a time, oldest first. It watches empty, full and a sticky overflow flag. Overflow means that history was lost because an unread entry was replaced.

Top module: `cof_trace_buffer`

## Requirements
- R1: After reset, buf_empty is 1, and buf_full, overflow and rd_valid are 0.
- R2: With class_en bit 0 set, an event of kind 1 (interrupt entry) stores ev_vector, and an event of kind 2 (return from interrupt) stores ev_target.
- R3: With class_en bit 1 set, an event of kind 3 (subroutine call) stores ev_target.
- R4: With class_en bit 2 set, an event of kind 4 (conditional or bit-test branch) or kind 5 (conditional jump) with ev_taken low stores ev_target.
- R5: With class_en bit 3 set, the following events store ev_target: a taken kind 5 event, and a taken kind 4 event whose ev_target is greater than ev_pc.
- R6: With class_en bit 4 set, a taken kind 4 event whose ev_target is less than or equal to ev_pc stores ev_target.
- R7: Nothing is stored in these cases: ev_valid is low, the kind is 0, 6 or 7, or the event's class bit is clear.
- R8: A read request while entries are unread raises rd_valid on the next cycle, with the oldest unread entry on rd_data, and consumes that entry. A read request while buf_empty is high is ignored, and rd_valid stays low.
- R9: buf_full is high while 8 entries are unread. A store while full without a same-cycle read replaces the oldest entry, so the next read returns the second-oldest. It also sets overflow, which stays set until reset. A store and a read in the same cycle while full lose nothing.
- R10: buf_empty is high exactly when no unread entries remain. A store into an empty buffer in the same cycle as a read request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| class_en | input | 5 | Class mask: 0 interrupt, 1 call, 2 not-taken, 3 forward/jump, 4 backward |
| ev_valid | input | 1 | A flow event is presented this cycle |
| ev_kind | input | 3 | Event kind code (see R2 to R7) |
| ev_taken | input | 1 | Conditional transfer was taken |
| ev_pc | input | AW (16) | Program counter of the event |
| ev_target | input | AW (16) | Destination address |
| ev_vector | input | AW (16) | Interrupt vector address |
| rd_req | input | 1 | Host read request |
| rd_data | output | AW (16) | Entry returned by the last read |
| rd_valid | output | 1 | rd_data holds a new entry this cycle |
| buf_empty | output | 1 | No unread entries |
| buf_full | output | 1 | Eight unread entries |
| overflow | output | 1 | Sticky: an unread entry was lost |

## Verification
The bench aims at these corner cases:

- A branch whose destination equals its program counter. A design that used a strict less-than for backward would drop it from the backward class, or file it as forward.
- Writing into a full ring, with and without a same-cycle read. A wrong design would lose the wrong entry, would flag overflow when nothing was lost, or would return entries out of order after the wrap.
- A read request on an empty ring in the same cycle as a store. A design that read the stale slot would emit a bogus rd_valid, or would drop the new entry.
- Not-taken events, which must reach the not-taken class only. A design keyed on kind alone would also feed them to the forward or backward classes.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_IRQ    = 3'd1,
    EV_RTI    = 3'd2,
    EV_CALL   = 3'd3,
    EV_BRANCH = 3'd4,
    EV_JUMP   = 3'd5
  } ev_kind_e;

  localparam int CLS_IRQ  = 0;
  localparam int CLS_CALL = 1;
  localparam int CLS_NT   = 2;
  localparam int CLS_FWD  = 3;
  localparam int CLS_BWD  = 4;
  localparam int NUM_CLS  = 5;

  // Forward means strictly above the current program counter.
  function automatic logic is_forward(input logic [31:0] tgt, input logic [31:0] pc);
    return tgt > pc;
  endfunction

endpackage

// File: rtl/cof_classify.sv
module cof_classify
  import cof_trace_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [NUM_CLS-1:0] class_en,
  input  logic               ev_valid,
  input  logic [2:0]         ev_kind,
  input  logic               ev_taken,
  input  logic [AW-1:0]      ev_pc,
  input  logic [AW-1:0]      ev_target,
  input  logic [AW-1:0]      ev_vector,
  output logic               hit,
  output logic [AW-1:0]      addr
);

  ev_kind_e kind;
  logic     fwd;
  logic     cls_hit;

  assign kind = ev_kind_e'(ev_kind);
  assign fwd  = is_forward(32'(ev_target), 32'(ev_pc));

  always_comb begin
    cls_hit = 1'b0;
    addr    = ev_target;
    unique case (kind)
      EV_IRQ: begin
        cls_hit = class_en[CLS_IRQ];
        addr    = ev_vector;
      end
      EV_RTI:  cls_hit = class_en[CLS_IRQ];
      EV_CALL: cls_hit = class_en[CLS_CALL];
      EV_BRANCH: begin
        if (!ev_taken)
          cls_hit = class_en[CLS_NT];
        else if (fwd)
          cls_hit = class_en[CLS_FWD];
        else
          cls_hit = class_en[CLS_BWD];
      end
      EV_JUMP:
        cls_hit = ev_taken ? class_en[CLS_FWD] : class_en[CLS_NT];
      default: cls_hit = 1'b0;
    endcase
  end

  assign hit = ev_valid && cls_hit;

endmodule

// File: rtl/cof_ring.sv
module cof_ring #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_req,
  output logic [AW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full,
  output logic          overflow,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_rd, drop;

  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign do_rd    = rd_req && !empty;
  assign drop     = wr_en && full && !do_rd;
  assign wr_ptr_o = wr_ptr;
  assign rd_ptr_o = rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= mem[rd_ptr];
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd || drop) rd_ptr <= rd_ptr + 1'b1;
      if (wr_en && !do_rd && !full) count <= count + 1'b1;
      else if (do_rd && !wr_en)     count <= count - 1'b1;
      if (drop) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/cof_trace_buffer.sv
module cof_trace_buffer
  import cof_trace_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] class_en,
  input  logic               ev_valid,
  input  logic [2:0]         ev_kind,
  input  logic               ev_taken,
  input  logic [AW-1:0]      ev_pc,
  input  logic [AW-1:0]      ev_target,
  input  logic [AW-1:0]      ev_vector,
  input  logic               rd_req,
  output logic [AW-1:0]      rd_data,
  output logic               rd_valid,
  output logic               buf_empty,
  output logic               buf_full,
  output logic               overflow
);

  logic          cap_hit;
  logic [AW-1:0] cap_addr;
  logic [PW-1:0] wr_ptr, rd_ptr;

  cof_classify #(.AW(AW)) u_classify (
    .class_en (class_en),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_taken (ev_taken),
    .ev_pc    (ev_pc),
    .ev_target(ev_target),
    .ev_vector(ev_vector),
    .hit      (cap_hit),
    .addr     (cap_addr)
  );

  cof_ring #(.AW(AW), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cap_hit),
    .wr_data (cap_addr),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .empty   (buf_empty),
    .full    (buf_full),
    .overflow(overflow),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr)
  );

endmodule

// File: rtl/cof_trace_buffer_chk.sv
module cof_trace_buffer_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_hit,
  input logic [PW-1:0] wr_ptr,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          buf_empty,
  input logic          buf_full,
  input logic          overflow
);

  // R9
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !buf_empty);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && buf_full && !rd_req) |=> overflow);

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && buf_empty) |=> !rd_valid);

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !buf_empty) |=> rd_valid);

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(wr_ptr));

  // R10
  store_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && !rd_req) |=> !buf_empty);

endmodule

bind cof_trace_buffer cof_trace_buffer_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_hit  (cap_hit),
  .wr_ptr   (wr_ptr),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .buf_empty(buf_empty),
  .buf_full (buf_full),
  .overflow (overflow)
);

// File: tb/cof_trace_buffer_test.sv
`timescale 1ns/1ps
module cof_trace_buffer_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    class_en = '0;
  logic          ev_valid = 1'b0;
  logic [2:0]    ev_kind = '0;
  logic          ev_taken = 1'b0;
  logic [AW-1:0] ev_pc = '0, ev_target = '0, ev_vector = '0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_data;
  logic          rd_valid, buf_empty, buf_full, overflow;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] mq_addr[$];
  string         mq_tag[$];
  logic          exp_valid = 1'b0;
  logic [AW-1:0] exp_data = '0;
  string         exp_tag = "R8";
  logic          exp_ovf = 1'b0;

  always #2 clk = ~clk;

  cof_trace_buffer uut (
    .clk(clk), .rst_n(rst_n), .class_en(class_en), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .ev_taken(ev_taken), .ev_pc(ev_pc),
    .ev_target(ev_target), .ev_vector(ev_vector), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .buf_empty(buf_empty),
    .buf_full(buf_full), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference selection, laid out by class rather than by kind.
  function automatic bit ref_pick(input logic [4:0] en, input logic v, input logic [2:0] k,
                                  input logic tk, input logic [AW-1:0] pc,
                                  input logic [AW-1:0] tg, input logic [AW-1:0] vec,
                                  output logic [AW-1:0] a, output string tag);
    bit cond = (k == 3'd4) || (k == 3'd5);
    a = tg; tag = "";
    if (!v) return 0;
    if (en[0] && k == 3'd1) begin a = vec; tag = "R2"; return 1; end
    if (en[0] && k == 3'd2) begin tag = "R2"; return 1; end
    if (en[1] && k == 3'd3) begin tag = "R3"; return 1; end
    if (en[2] && cond && !tk) begin tag = "R4"; return 1; end
    if (en[3] && cond && tk && (k == 3'd5 || tg > pc)) begin tag = "R5"; return 1; end
    if (en[4] && k == 3'd4 && tk && !(tg > pc)) begin tag = "R6"; return 1; end
    return 0;
  endfunction

  task automatic step(input logic [4:0] en, input logic v, input logic [2:0] k,
                      input logic tk, input logic [AW-1:0] pc, input logic [AW-1:0] tg,
                      input logic [AW-1:0] vec, input logic rd);
    logic [AW-1:0] a;
    string t;
    bit hit;
    @(negedge clk);
    chk("R8 rd_valid", 32'(rd_valid), 32'(exp_valid));
    if (exp_valid) chk({exp_tag, " rd_data"}, 32'(rd_data), 32'(exp_data));
    chk("R10 buf_empty", 32'(buf_empty), 32'(mq_addr.size() == 0));
    chk("R9 buf_full", 32'(buf_full), 32'(mq_addr.size() == 8));
    chk("R9 overflow", 32'(overflow), 32'(exp_ovf));
    class_en = en; ev_valid = v; ev_kind = k; ev_taken = tk;
    ev_pc = pc; ev_target = tg; ev_vector = vec; rd_req = rd;
    exp_valid = 1'b0;
    if (rd && mq_addr.size() > 0) begin
      exp_valid = 1'b1;
      exp_data = mq_addr.pop_front();
      exp_tag = mq_tag.pop_front();
    end
    hit = ref_pick(en, v, k, tk, pc, tg, vec, a, t);
    if (hit) begin
      mq_addr.push_back(a);
      mq_tag.push_back(t);
      if (mq_addr.size() > 8) begin
        void'(mq_addr.pop_front());
        void'(mq_tag.pop_front());
        exp_ovf = 1'b1;
      end
    end
  endtask

  task automatic idle(input int n, input logic rd);
    for (int i = 0; i < n; i++) step('0, 1'b0, 3'd0, 1'b0, '0, '0, '0, rd);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", 32'(buf_empty), 32'd1);
    chk("R1 full", 32'(buf_full), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);

    // R7: disabled classes, invalid events, unused kinds
    for (int k = 1; k < 6; k++) step(5'b00000, 1'b1, 3'(k), 1'b1, 16'h10, 16'h20, 16'h30, 1'b0);
    step(5'b11111, 1'b0, 3'd3, 1'b1, 16'h10, 16'h20, 16'h30, 1'b0);
    for (int k = 6; k < 8; k++) step(5'b11111, 1'b1, 3'(k), 1'b1, 16'h10, 16'h20, 16'h30, 1'b0);
    step(5'b01000, 1'b1, 3'd4, 1'b1, 16'h40, 16'h40, 16'h0, 1'b0);  // equal: not forward
    step(5'b00011, 1'b1, 3'd4, 1'b0, 16'h40, 16'h44, 16'h0, 1'b0);  // not-taken, class off
    idle(1, 1'b1);
    chk("R7 nothing stored", 32'(buf_empty), 32'd1);

    // R8: read on empty in the same cycle as a store
    step(5'b00010, 1'b1, 3'd3, 1'b1, 16'h100, 16'h1234, 16'h0, 1'b1);
    idle(1, 1'b0);
    chk("R10 store kept", 32'(buf_empty), 32'd0);
    idle(2, 1'b1);

    // each class, including target equal to pc (backward)
    step(5'b00001, 1'b1, 3'd1, 1'b0, 16'h200, 16'h210, 16'hFF04, 1'b0);
    step(5'b00001, 1'b1, 3'd2, 1'b0, 16'h300, 16'h2A2, 16'h0, 1'b0);
    step(5'b00100, 1'b1, 3'd5, 1'b0, 16'h300, 16'h3A0, 16'h0, 1'b0);
    step(5'b01000, 1'b1, 3'd5, 1'b1, 16'h300, 16'h100, 16'h0, 1'b0);
    step(5'b01000, 1'b1, 3'd4, 1'b1, 16'h300, 16'h301, 16'h0, 1'b0);
    step(5'b10000, 1'b1, 3'd4, 1'b1, 16'h300, 16'h300, 16'h0, 1'b0);
    step(5'b10000, 1'b1, 3'd4, 1'b1, 16'h300, 16'h2FF, 16'h0, 1'b0);
    idle(9, 1'b1);

    // R9: overflow, then full with simultaneous read and write
    for (int i = 0; i < 11; i++)
      step(5'b00010, 1'b1, 3'd3, 1'b1, '0, 16'(16'hA00 + i), '0, 1'b0);
    step(5'b00010, 1'b1, 3'd3, 1'b1, '0, 16'hBEEF, '0, 1'b1);
    idle(10, 1'b1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] k = 3'($urandom_range(0, 7));
      logic [AW-1:0] pc = 16'($urandom_range(0, 15));
      logic [AW-1:0] tg = 16'($urandom_range(0, 15));
      step(5'($urandom), ($urandom_range(0, 9) != 0), k, 1'($urandom),
           pc, tg, 16'($urandom), ($urandom_range(0, 2) == 0));
    end
    idle(12, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule